// File: doc/BRIEF.md
# Operand Shifter with Carry-Out

This block forms the second operand of an integer ALU. It takes a data word, a two-bit shift kind, an eight-bit shift count, a flag that says whether the count came from a five-bit immediate field or from a register, and the current carry flag. It returns the shifted word and the carry-out that the ALU may write into its flags. The outputs are registered, so a result appears one clock after its inputs are presented, and a new operation can start on every cycle.

The shift kinds are logical left, logical right, arithmetic right and rotate right. A fifth operation, a one-bit rotate through the carry, is reached by giving a rotate an immediate count of zero. The count can take any value from 0 to 255. A count of zero and counts of the word width or more have their own rules for the result and the carry. The caller extracts the instruction fields and reads the register file before driving this block.

Top module: `operand_shifter`

## Requirements
- R1: While `rst` is high at a rising edge, `result` and `carry_out` become zero on that edge. Otherwise the outputs present the operation applied at the previous rising edge.
- R2: `kind` is encoded as 2'b00 logical left, 2'b01 logical right, 2'b10 arithmetic right and 2'b11 rotate right. For a logical left shift by n in 1..31, the result is the value shifted left by n and the carry is value bit (32 - n).
- R3: A logical left shift by 32 gives a zero result and carry = value bit 0. A logical left shift by more than 32 gives a zero result and a zero carry.
- R4: A logical right shift by n in 1..32 gives the value shifted right with zero fill and carry = value bit (n - 1). A count above 32 gives a zero result and a zero carry.
- R5: An arithmetic right shift by n in 1..31 fills with the sign bit and sets carry = value bit (n - 1). A count of 32 or more gives 32 copies of bit 31 and carry = bit 31.
- R6: A rotate right by a nonzero count n rotates by n mod 32 and sets carry = value bit ((n - 1) mod 32). When n is a multiple of 32, the value is unchanged and the carry is bit 31.
- R7: A rotate right with an immediate count of 0 is a one-bit rotate through the carry. The result is {carry_in, value[31:1]} and carry_out = value bit 0.
- R8: A logical or arithmetic right shift with an immediate count of 0 acts as a shift by 32.
- R9: A register count of 0 with any kind, or a logical left shift with an immediate count of 0, passes the value through unchanged and keeps `carry_in`.
- R10: When `amt_is_imm` is high, only `amount[4:0]` is used and `amount[7:5]` has no effect on the result or the carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| value | input | 32 | Word to be shifted |
| kind | input | 2 | Shift kind (see R2) |
| amount | input | 8 | Shift count; only the low 5 bits are used when the count is immediate |
| amt_is_imm | input | 1 | High when the count comes from the immediate field |
| carry_in | input | 1 | Current carry flag |
| result | output | 32 | Registered shifted word |
| carry_out | output | 1 | Registered carry-out |

## Verification
Two things can land in the same cycle. A rotate through the carry consumes the carry flag while it produces a new one. An immediate count whose low five bits are zero switches the operation while its ignored upper bits are nonzero. The bench exercises the first with a chain of rotate-through-carry operations. Each operation takes as its `carry_in` the `carry_out` of the operation before it, so one wrong carry spoils every later word in the chain, and every link is compared with a bench model. The second is covered by immediate counts of zero whose upper bits are set, mixed into both directed cases and random traffic. The bench checks that the aliased operation, not a plain shift, comes out one cycle later.

// File: rtl/shifter_pkg.sv
package shifter_pkg;
  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;

  typedef enum logic [2:0] {
    OP_PASS,
    OP_LSL,
    OP_LSR,
    OP_ASR,
    OP_ROR,
    OP_RRX
  } shift_op_e;
endpackage

// File: rtl/shift_decode.sv
module shift_decode
  import shifter_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8,
  parameter int IMM_W = 5
) (
  input  logic [1:0]       kind,
  input  logic [AMT_W-1:0] amount,
  input  logic             amt_is_imm,
  output shift_op_e        op,
  output logic [AMT_W-1:0] count
);
  localparam logic [AMT_W-1:0] FULL = AMT_W'(W);

  logic [IMM_W-1:0] imm_cnt;
  assign imm_cnt = amount[IMM_W-1:0];

  function automatic shift_op_e kind_to_op(input logic [1:0] k);
    case (k)
      SK_LSL:  return OP_LSL;
      SK_LSR:  return OP_LSR;
      SK_ASR:  return OP_ASR;
      default: return OP_ROR;
    endcase
  endfunction

  always_comb begin
    op    = OP_PASS;
    count = '0;
    if (amt_is_imm) begin
      if (imm_cnt == '0) begin
        // a zero immediate count aliases to a different operation
        case (kind)
          SK_LSL:  op = OP_PASS;
          SK_LSR:  begin op = OP_LSR; count = FULL; end
          SK_ASR:  begin op = OP_ASR; count = FULL; end
          default: op = OP_RRX;
        endcase
      end else begin
        op    = kind_to_op(kind);
        count = AMT_W'(imm_cnt);
      end
    end else if (amount != '0) begin
      op    = kind_to_op(kind);
      count = amount;
    end
  end
endmodule

// File: rtl/shift_core.sv
module shift_core
  import shifter_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8
) (
  input  shift_op_e        op,
  input  logic [AMT_W-1:0] count,
  input  logic [W-1:0]     value,
  input  logic             carry_in,
  output logic [W-1:0]     res,
  output logic             cout
);
  localparam int LW = $clog2(W);
  localparam logic [AMT_W-1:0] FULL = AMT_W'(W);

  logic [LW-1:0]  low;       // count mod W
  logic [LW-1:0]  left_idx;  // W - count, mod W
  logic [LW-1:0]  right_idx; // count - 1, mod W
  logic [2*W-1:0] dbl;

  assign low       = count[LW-1:0];
  assign left_idx  = ~low + 1'b1;
  assign right_idx = low - 1'b1;
  assign dbl       = {value, value} >> low;

  always_comb begin
    res  = value;
    cout = carry_in;
    case (op)
      OP_LSL: begin
        if (count < FULL) begin
          res  = value << count;
          cout = value[left_idx];
        end else if (count == FULL) begin
          res  = '0;
          cout = value[0];
        end else begin
          res  = '0;
          cout = 1'b0;
        end
      end
      OP_LSR: begin
        if (count <= FULL) begin
          res  = (count == FULL) ? '0 : (value >> count);
          cout = value[right_idx];
        end else begin
          res  = '0;
          cout = 1'b0;
        end
      end
      OP_ASR: begin
        if (count < FULL) begin
          res  = W'($signed(value) >>> count);
          cout = value[right_idx];
        end else begin
          res  = {W{value[W-1]}};
          cout = value[W-1];
        end
      end
      OP_ROR: begin
        res  = dbl[W-1:0];
        cout = value[right_idx];
      end
      OP_RRX: begin
        res  = {carry_in, value[W-1:1]};
        cout = value[0];
      end
      default: begin
        res  = value;
        cout = carry_in;
      end
    endcase
  end
endmodule

// File: rtl/operand_shifter.sv
module operand_shifter
  import shifter_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8,
  parameter int IMM_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     value,
  input  logic [1:0]       kind,
  input  logic [AMT_W-1:0] amount,
  input  logic             amt_is_imm,
  input  logic             carry_in,
  output logic [W-1:0]     result,
  output logic             carry_out
);
  shift_op_e        op;
  logic [AMT_W-1:0] count;
  logic [W-1:0]     res_d;
  logic             cout_d;

  shift_decode #(.W(W), .AMT_W(AMT_W), .IMM_W(IMM_W)) u_dec (
    .kind       (kind),
    .amount     (amount),
    .amt_is_imm (amt_is_imm),
    .op         (op),
    .count      (count)
  );

  shift_core #(.W(W), .AMT_W(AMT_W)) u_core (
    .op       (op),
    .count    (count),
    .value    (value),
    .carry_in (carry_in),
    .res      (res_d),
    .cout     (cout_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      carry_out <= 1'b0;
    end else begin
      result    <= res_d;
      carry_out <= cout_d;
    end
  end
endmodule

// File: rtl/operand_shifter_chk.sv
module operand_shifter_chk #(
  parameter int W     = 32,
  parameter int AMT_W = 8,
  parameter int IMM_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [W-1:0]     value,
  input logic [1:0]       kind,
  input logic [AMT_W-1:0] amount,
  input logic             amt_is_imm,
  input logic             carry_in,
  input logic [W-1:0]     result,
  input logic             carry_out
);
  localparam logic [AMT_W-1:0] FULL = AMT_W'(W);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (result == '0 && !carry_out));

  // R9
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    (!amt_is_imm && amount == '0) |=>
      (result == $past(value) && carry_out == $past(carry_in)));

  // R7
  rrx_chk: assert property (@(posedge clk) disable iff (rst)
    (amt_is_imm && amount[IMM_W-1:0] == '0 && kind == 2'b11) |=>
      (result == {$past(carry_in), $past(value[W-1:1])} &&
       carry_out == $past(value[0])));

  // R3
  lsl_overrun_chk: assert property (@(posedge clk) disable iff (rst)
    (!amt_is_imm && kind == 2'b00 && amount > FULL) |=>
      (result == '0 && !carry_out));

  // R5
  asr_saturate_chk: assert property (@(posedge clk) disable iff (rst)
    (!amt_is_imm && kind == 2'b10 && amount >= FULL) |=>
      (result == {W{$past(value[W-1])}} && carry_out == $past(value[W-1])));

  // R8
  lsr_imm_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (amt_is_imm && amount[IMM_W-1:0] == '0 && kind == 2'b01) |=>
      (result == '0 && carry_out == $past(value[W-1])));
endmodule

bind operand_shifter operand_shifter_chk #(.W(W), .AMT_W(AMT_W), .IMM_W(IMM_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .value      (value),
  .kind       (kind),
  .amount     (amount),
  .amt_is_imm (amt_is_imm),
  .carry_in   (carry_in),
  .result     (result),
  .carry_out  (carry_out)
);

// File: tb/tb_operand_shifter.sv
module tb_operand_shifter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] value = '0;
  logic [1:0]  kind = '0;
  logic [7:0]  amount = '0;
  logic        amt_is_imm = 1'b0;
  logic        carry_in = 1'b0;
  logic [31:0] result;
  logic        carry_out;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  operand_shifter dut (
    .clk(clk), .rst(rst), .value(value), .kind(kind), .amount(amount),
    .amt_is_imm(amt_is_imm), .carry_in(carry_in),
    .result(result), .carry_out(carry_out)
  );

  // returns {carry, result}
  function automatic logic [32:0] model(input logic [31:0] v, input logic [1:0] k,
                                        input logic [7:0] a, input logic imm,
                                        input logic c);
    int n;
    logic [63:0] t;
    int r;
    logic [31:0] rr;
    if (imm) begin
      n = int'(a[4:0]);
      if (n == 0) begin
        if (k == 2'b00) return {c, v};
        if (k == 2'b11) return {v[0], c, v[31:1]};
        n = 32;
      end
    end else begin
      n = int'(a);
      if (n == 0) return {c, v};
    end
    case (k)
      2'b00: begin t = {32'b0, v} << n; return {t[32], t[31:0]}; end
      2'b01: begin t = {v, 32'b0} >> n; return {t[31], t[63:32]}; end
      2'b10: begin
        t = 64'($signed({v, 32'b0}) >>> (n > 63 ? 63 : n));
        return {t[31], t[63:32]};
      end
      default: begin
        r = n % 32;
        rr = (r == 0) ? v : ((v >> r) | (v << (32 - r)));
        return {v[(n - 1) % 32], rr};
      end
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] k, input logic [7:0] a,
                                   input logic imm);
    if (imm && a[4:0] == 5'd0) return (k == 2'b00) ? "R9" : (k == 2'b11) ? "R7" : "R8";
    if (imm && a[7:5] != 3'd0) return "R10";
    if (!imm && a == 8'd0) return "R9";
    case (k)
      2'b00:   return (!imm && a >= 8'd32) ? "R3" : "R2";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  // called just after a falling edge; returns after the result is sampled
  task automatic run_op(input logic [31:0] v, input logic [1:0] k, input logic [7:0] a,
                        input logic imm, input logic c, input string tag);
    logic [32:0] exp;
    exp = model(v, k, a, imm, c);
    value = v; kind = k; amount = a; amt_is_imm = imm; carry_in = c;
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (result !== exp[31:0] || carry_out !== exp[32]) begin
      failures++;
      $display("FAIL %s v=%h k=%0d a=%0d imm=%0b c=%0b : got %h/%0b expected %h/%0b",
               tag, v, k, a, imm, c, result, carry_out, exp[31:0], exp[32]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic cy;
    seed = $urandom(32'd20240917);
    value = 32'hDEADBEEF; kind = 2'b11; amount = 8'd5; carry_in = 1'b1;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    checks++;
    if (result !== 32'h0 || carry_out !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset: got %h/%0b expected 0/0", result, carry_out);
    end
    rst = 1'b0;

    // directed corners
    run_op(32'h8000_0001, 2'b00, 8'd1,   1'b0, 1'b0, "R2");
    run_op(32'h4000_0000, 2'b00, 8'd2,   1'b0, 1'b0, "R2");
    run_op(32'h0000_0001, 2'b00, 8'd32,  1'b0, 1'b0, "R3");
    run_op(32'hFFFF_FFFF, 2'b00, 8'd33,  1'b0, 1'b1, "R3");
    run_op(32'hFFFF_FFFF, 2'b00, 8'd255, 1'b0, 1'b1, "R3");
    run_op(32'h8000_0000, 2'b01, 8'd32,  1'b0, 1'b0, "R4");
    run_op(32'hFFFF_FFFF, 2'b01, 8'd33,  1'b0, 1'b1, "R4");
    run_op(32'h0000_0010, 2'b01, 8'd5,   1'b0, 1'b0, "R4");
    run_op(32'h8000_0040, 2'b10, 8'd7,   1'b0, 1'b0, "R5");
    run_op(32'h8000_0000, 2'b10, 8'd200, 1'b0, 1'b0, "R5");
    run_op(32'h7FFF_FFFF, 2'b10, 8'd32,  1'b0, 1'b1, "R5");
    run_op(32'h8000_0001, 2'b11, 8'd32,  1'b0, 1'b0, "R6");
    run_op(32'h0000_0002, 2'b11, 8'd34,  1'b0, 1'b0, "R6");
    run_op(32'h1234_5678, 2'b11, 8'd64,  1'b0, 1'b0, "R6");
    run_op(32'h0000_0003, 2'b11, 8'd0,   1'b1, 1'b1, "R7");
    run_op(32'h0000_0002, 2'b11, 8'd0,   1'b1, 1'b0, "R7");
    run_op(32'h8000_0000, 2'b01, 8'd0,   1'b1, 1'b0, "R8");
    run_op(32'h8000_0000, 2'b10, 8'd0,   1'b1, 1'b0, "R8");
    run_op(32'hCAFE_F00D, 2'b10, 8'd0,   1'b0, 1'b1, "R9");
    run_op(32'hCAFE_F00D, 2'b11, 8'd0,   1'b0, 1'b0, "R9");
    run_op(32'hCAFE_F00D, 2'b00, 8'd0,   1'b1, 1'b1, "R9");
    run_op(32'h8000_0001, 2'b00, 8'hE1,  1'b1, 1'b0, "R10");
    run_op(32'h0000_0003, 2'b11, 8'hE0,  1'b1, 1'b1, "R10");
    run_op(32'h8000_0000, 2'b01, 8'h20,  1'b1, 1'b1, "R10");

    // carry chain through repeated rotate-with-extend
    cy = 1'b1;
    for (int i = 0; i < 40; i++) begin
      run_op(32'hA5A5_0F0F ^ (32'(i) << 3), 2'b11, 8'h00, 1'b1, cy, "R7");
      cy = carry_out;
    end

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] v;
      logic [1:0]  k;
      logic [7:0]  a;
      logic        imm;
      logic        c;
      v = $urandom();
      k = 2'($urandom_range(0, 3));
      imm = 1'($urandom_range(0, 1));
      c = 1'($urandom_range(0, 1));
      case ($urandom_range(0, 3))
        0:       a = 8'($urandom_range(0, 255));
        1:       a = 8'($urandom_range(28, 36));
        2:       a = 8'($urandom_range(0, 3));
        default: a = {3'($urandom_range(0, 7)), 5'($urandom_range(0, 1))};
      endcase
      run_op(v, k, a, imm, c, tag_of(k, a, imm));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule